// File: doc/BRIEF.md
# Divider Setting Search Engine

This block chooses the two settings of a clock divider chain, a 4-bit multiplier-style index M and a 3-bit shift index N. The choice gives the rate that comes closest to a requested rate without going above it. The chain takes the parent clock rate and divides it by a programmable pre-divider. It then divides by a fixed constant of ten, shifts right by N, and divides by the sum of M and a programmable offset. Each stage truncates toward zero.

Software, or a neighbouring controller, places the parent rate, the target rate, the pre-divider and the offset on the inputs, then pulses `start`. The engine walks all 128 (M, N) pairs with M as the outer index and N as the inner one. One restoring divider is shared by every division. When the search ends, the block pulses `done` for one cycle and presents the winning M, N and the rate they produce. The results stay on the outputs until the next accepted start.

Top module: `rate_div_search`

## Requirements
- R1: After reset `busy` and `done` are 0 and `best_m`, `best_n` and `best_rate` are all 0.
- R2: Each search visits every pair with M from 0 to 15 and N from 0 to 7, in M-major order: for a given M all N values come before M+1.
- R3: A candidate's rate is computed as ((((parent / pre) / 10) >> N) / (M + offset)), with truncating unsigned division at every stage and 32-bit rates.
- R4: A candidate whose rate is greater than the target rate is never chosen, so a reported `best_rate` never exceeds the target captured at start.
- R5: A candidate replaces the current best only when its distance to the target is strictly smaller. When two pairs tie, the earlier pair in scan order is the result.
- R6: The best starts each search as rate 0 with M 0 and N 0. If no candidate beats that distance, the block reports all zeros.
- R7: A pair whose M + offset is zero is skipped and never divides. A pre-divider of zero makes the base rate zero, so the result is all zeros.
- R8: `done` is high for exactly one cycle, with `busy` low in that cycle. From that cycle until the next accepted start, `best_m`, `best_n` and `best_rate` do not change.
- R9: While `busy` is high, `start` is ignored. A running search neither restarts nor takes up new input values.
- R10: When `start` is high in a cycle with `busy` low, including the cycle in which `done` is high, a new search is accepted and `busy` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a search; sampled only while idle |
| parent_rate | input | 32 | Parent clock rate, unsigned |
| target_rate | input | 32 | Requested output rate, unsigned |
| pre_div | input | 8 | Pre-divider applied first |
| m_offset | input | 8 | Offset added to M before the last division |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when a search completes |
| best_m | output | 4 | Chosen M |
| best_n | output | 3 | Chosen N |
| best_rate | output | 32 | Rate produced by the chosen pair |

## Verification
Completion and acceptance can fall in the same cycle. In the cycle where `done` pulses, `busy` is already low, so a `start` held high through the end of a search launches the next one at once. The bench provokes this by keeping `start` high across two searches. It checks that the first result appears with `done` while its model queues a second expected result and sees `busy` return on the following cycle. A `start` pulse with changed inputs in the middle of a search checks the opposite case: the queued result must still match the first input set.

// File: rtl/rds_pkg.sv
// Package: shared state encoding for the divider setting search engine.
// Assumes: nothing beyond a standard SystemVerilog compilation unit.
package rds_pkg;

    // Scan controller states, in the order a search moves through them
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_FIXED,
        ST_PICK,
        ST_WAIT,
        ST_FIN
    } scan_state_e;

endpackage

// File: rtl/rds_divider.sv
// Module: rds_divider
// Unsigned restoring divider, one quotient bit per clock. A go pulse while
// idle loads the operands. After W iteration cycles, done pulses for one
// cycle with the quotient valid in that same cycle. The quotient is held
// until the next go.
// Assumes: go is ignored while a division runs; a zero divisor yields 0.
module rds_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CNT_W = $clog2(W + 1);

    logic             running;
    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     rem;
    logic [W-1:0]     quo;
    logic [W-1:0]     dvs;
    logic             by_zero;
    logic [W:0]       shl;
    logic [W:0]       trial;

    // Shift next dividend bit into the partial remainder and try a subtract
    always_comb begin
        shl   = {rem, quo[W-1]};
        trial = shl - {1'b0, dvs};
    end

    // Load operands on go, then iterate one quotient bit per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
            rem     <= '0;
            quo     <= '0;
            dvs     <= '0;
            by_zero <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !running) begin
                rem     <= '0;
                quo     <= dividend;
                dvs     <= divisor;
                by_zero <= (divisor == '0);
                cnt     <= CNT_W'(W);
                running <= 1'b1;
            end else if (running) begin
                if (!trial[W]) begin
                    rem <= trial[W-1:0];
                    quo <= {quo[W-2:0], 1'b1};
                end else begin
                    rem <= shl[W-1:0];
                    quo <= {quo[W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

    // Zero divisor forces a zero result
    always_comb quotient = by_zero ? '0 : quo;

endmodule

// File: rtl/rds_best.sv
// Module: rds_best
// Keeps the best candidate of a search. A candidate is taken when its rate
// is not above the target and its distance to the target is strictly
// smaller than the current best's. The best resets to zero rate, M 0, N 0
// on clear.
// Assumes: cand_valid is a one-cycle strobe; clear and cand_valid never coincide.
module rds_best #(
    parameter int RATE_W = 32,
    parameter int M_W    = 4,
    parameter int N_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              cand_valid,
    input  logic [RATE_W-1:0] cand_rate,
    input  logic [M_W-1:0]    cand_m,
    input  logic [N_W-1:0]    cand_n,
    input  logic [RATE_W-1:0] target,
    output logic [RATE_W-1:0] best_rate,
    output logic [M_W-1:0]    best_m,
    output logic [N_W-1:0]    best_n
);
    logic take;

    function automatic logic [RATE_W-1:0] gap(input logic [RATE_W-1:0] a,
                                              input logic [RATE_W-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    // Decide whether the offered candidate improves on the held best
    always_comb begin
        take = cand_valid && (cand_rate <= target) &&
               (gap(target, cand_rate) < gap(target, best_rate));
    end

    // Hold the best pair, cleared at the start of every search
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            best_rate <= '0;
            best_m    <= '0;
            best_n    <= '0;
        end else if (take) begin
            best_rate <= cand_rate;
            best_m    <= cand_m;
            best_n    <= cand_n;
        end
    end

endmodule

// File: rtl/rds_scan.sv
// Module: rds_scan
// Search controller. On an accepted start it latches the inputs. It then
// computes the base rate (parent / pre / FIXED_DIV) once and walks every
// (M, N) pair in M-major order, issuing base >> N divided by M + offset to
// the shared divider. Each quotient goes to the best tracker. Pairs with a
// zero divisor are skipped.
// Assumes: the divider answers every go with exactly one done pulse.
module rds_scan
    import rds_pkg::*;
#(
    parameter int RATE_W    = 32,
    parameter int PRE_W     = 8,
    parameter int OFF_W     = 8,
    parameter int M_W       = 4,
    parameter int N_W       = 3,
    parameter int FIXED_DIV = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RATE_W-1:0] parent_rate,
    input  logic [RATE_W-1:0] target_rate,
    input  logic [PRE_W-1:0]  pre_div,
    input  logic [OFF_W-1:0]  m_offset,
    output logic              busy,
    output logic              done,
    output logic              div_go,
    output logic [RATE_W-1:0] div_a,
    output logic [RATE_W-1:0] div_b,
    input  logic              div_done,
    input  logic [RATE_W-1:0] div_q,
    output logic              trk_clear,
    output logic              cand_valid,
    output logic [RATE_W-1:0] cand_rate,
    output logic [M_W-1:0]    cand_m,
    output logic [N_W-1:0]    cand_n,
    output logic [RATE_W-1:0] tgt_q
);
    localparam logic [M_W-1:0] M_LAST = '1;
    localparam logic [N_W-1:0] N_LAST = '1;

    scan_state_e       state;
    logic [OFF_W-1:0]  off_q;
    logic [RATE_W-1:0] base;
    logic [M_W-1:0]    m_idx;
    logic [N_W-1:0]    n_idx;
    logic [RATE_W-1:0] pair_div;
    logic              last_pair;

    // Divisor of the current pair and end-of-scan detection
    always_comb begin
        pair_div  = RATE_W'(off_q) + RATE_W'(m_idx);
        last_pair = (m_idx == M_LAST) && (n_idx == N_LAST);
    end

    // Handshake and candidate strobes seen by the rest of the block
    always_comb begin
        busy       = (state != ST_IDLE);
        trk_clear  = (state == ST_IDLE) && start;
        cand_valid = (state == ST_WAIT) && div_done;
        cand_rate  = div_q;
        cand_m     = m_idx;
        cand_n     = n_idx;
    end

    // Main sequencer: base rate, then the M-major pair walk, then completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            off_q  <= '0;
            tgt_q  <= '0;
            base   <= '0;
            m_idx  <= '0;
            n_idx  <= '0;
            div_go <= 1'b0;
            div_a  <= '0;
            div_b  <= '0;
            done   <= 1'b0;
        end else begin
            div_go <= 1'b0;
            done   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        off_q  <= m_offset;
                        tgt_q  <= target_rate;
                        m_idx  <= '0;
                        n_idx  <= '0;
                        div_a  <= parent_rate;
                        div_b  <= RATE_W'(pre_div);
                        div_go <= 1'b1;
                        state  <= ST_PRE;
                    end
                end
                ST_PRE: begin
                    if (div_done) begin
                        div_a  <= div_q;
                        div_b  <= RATE_W'(FIXED_DIV);
                        div_go <= 1'b1;
                        state  <= ST_FIXED;
                    end
                end
                ST_FIXED: begin
                    if (div_done) begin
                        base  <= div_q;
                        state <= ST_PICK;
                    end
                end
                ST_PICK: begin
                    if (pair_div != '0) begin
                        div_a  <= base >> n_idx;
                        div_b  <= pair_div;
                        div_go <= 1'b1;
                        state  <= ST_WAIT;
                    end else if (last_pair) begin
                        state <= ST_FIN;
                    end else begin
                        n_idx <= n_idx + 1'b1;
                        if (n_idx == N_LAST) m_idx <= m_idx + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (div_done) begin
                        if (last_pair) begin
                            state <= ST_FIN;
                        end else begin
                            n_idx <= n_idx + 1'b1;
                            if (n_idx == N_LAST) m_idx <= m_idx + 1'b1;
                            state <= ST_PICK;
                        end
                    end
                end
                ST_FIN: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rate_div_search.sv
// Module: rate_div_search (top)
// Finds the (M, N) divider settings whose chain output is closest to, and
// not above, a requested rate. It is built from the scan controller, one
// shared restoring divider and the best tracker.
// Assumes: inputs are sampled only on the accepted start cycle.
module rate_div_search #(
    parameter int RATE_W    = 32,
    parameter int PRE_W     = 8,
    parameter int OFF_W     = 8,
    parameter int M_W       = 4,
    parameter int N_W       = 3,
    parameter int FIXED_DIV = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RATE_W-1:0] parent_rate,
    input  logic [RATE_W-1:0] target_rate,
    input  logic [PRE_W-1:0]  pre_div,
    input  logic [OFF_W-1:0]  m_offset,
    output logic              busy,
    output logic              done,
    output logic [M_W-1:0]    best_m,
    output logic [N_W-1:0]    best_n,
    output logic [RATE_W-1:0] best_rate
);
    logic              div_go;
    logic [RATE_W-1:0] div_a;
    logic [RATE_W-1:0] div_b;
    logic              div_done;
    logic [RATE_W-1:0] div_q;
    logic              trk_clear;
    logic              cand_valid;
    logic [RATE_W-1:0] cand_rate;
    logic [M_W-1:0]    cand_m;
    logic [N_W-1:0]    cand_n;
    logic [RATE_W-1:0] tgt_q;

    rds_scan #(
        .RATE_W(RATE_W), .PRE_W(PRE_W), .OFF_W(OFF_W),
        .M_W(M_W), .N_W(N_W), .FIXED_DIV(FIXED_DIV)
    ) u_scan (
        .clk(clk), .rst_n(rst_n), .start(start),
        .parent_rate(parent_rate), .target_rate(target_rate),
        .pre_div(pre_div), .m_offset(m_offset),
        .busy(busy), .done(done),
        .div_go(div_go), .div_a(div_a), .div_b(div_b),
        .div_done(div_done), .div_q(div_q),
        .trk_clear(trk_clear), .cand_valid(cand_valid),
        .cand_rate(cand_rate), .cand_m(cand_m), .cand_n(cand_n),
        .tgt_q(tgt_q)
    );

    rds_divider #(.W(RATE_W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go),
        .dividend(div_a), .divisor(div_b),
        .done(div_done), .quotient(div_q)
    );

    rds_best #(.RATE_W(RATE_W), .M_W(M_W), .N_W(N_W)) u_best (
        .clk(clk), .rst_n(rst_n), .clear(trk_clear),
        .cand_valid(cand_valid), .cand_rate(cand_rate),
        .cand_m(cand_m), .cand_n(cand_n), .target(tgt_q),
        .best_rate(best_rate), .best_m(best_m), .best_n(best_n)
    );

endmodule

// File: rtl/rds_checker.sv
// Module: rds_checker
// Protocol and result properties of rate_div_search, watched at its ports.
// Assumes: bound to every rate_div_search instance by the bind below.
module rds_checker #(
    parameter int RATE_W = 32,
    parameter int M_W    = 4,
    parameter int N_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [RATE_W-1:0] target_rate,
    input logic              busy,
    input logic              done,
    input logic [M_W-1:0]    best_m,
    input logic [N_W-1:0]    best_n,
    input logic [RATE_W-1:0] best_rate
);
    logic [RATE_W-1:0] tgt_seen;

    // Independent copy of the target taken on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n)              tgt_seen <= '0;
        else if (start && !busy) tgt_seen <= target_rate;
    end

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_busy_ends_in_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    assert_hold_while_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> ($stable(best_rate) && $stable(best_m) && $stable(best_n)));

    assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_not_above_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (best_rate <= tgt_seen));

endmodule

bind rate_div_search rds_checker #(.RATE_W(RATE_W), .M_W(M_W), .N_W(N_W)) u_rds_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .target_rate(target_rate),
    .busy(busy), .done(done), .best_m(best_m), .best_n(best_n),
    .best_rate(best_rate)
);

// File: tb/rate_div_search_bench.sv
// Bench for rate_div_search. A behavioural reference queues one expected
// result per accepted start. Every negative edge the model is compared with
// the ports: handshake shape, the result at done, and held outputs while idle.
module rate_div_search_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] parent_rate = '0;
    logic [31:0] target_rate = '0;
    logic [7:0]  pre_div = '0;
    logic [7:0]  m_offset = '0;
    logic        busy;
    logic        done;
    logic [3:0]  best_m;
    logic [2:0]  best_n;
    logic [31:0] best_rate;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    typedef struct {
        int     m;
        int     n;
        longint r;
    } exp_t;

    exp_t exp_q[$];
    exp_t last_exp;
    logic done_prev = 1'b0;
    logic want_busy = 1'b0;

    rate_div_search u_rate_div_search (
        .clk(clk), .rst_n(rst_n), .start(start),
        .parent_rate(parent_rate), .target_rate(target_rate),
        .pre_div(pre_div), .m_offset(m_offset),
        .busy(busy), .done(done),
        .best_m(best_m), .best_n(best_n), .best_rate(best_rate)
    );

    always #4 clk = ~clk;

    // Reference search written straight from the requirements (R2 R3 R5 R6 R7)
    function automatic exp_t model(input longint p, input longint t,
                                   input longint pre, input longint off);
        exp_t   e;
        longint base;
        e.m = 0; e.n = 0; e.r = 0;
        base = (pre == 0) ? 0 : (p / pre) / 10;
        for (int m = 0; m < 16; m++) begin
            for (int n = 0; n < 8; n++) begin
                longint s;
                longint r;
                s = m + off;
                if (s == 0) continue;
                r = (base >>> n) / s;
                if (r > t) continue;
                if ((t - r) < (t - e.r)) begin
                    e.r = r; e.m = m; e.n = n;
                end
            end
        end
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (rst_n) begin
            if (want_busy)
                check(busy == 1'b1, "R10", "busy after accepted start", busy, 1);
            want_busy = 1'b0;
            if (done) begin
                check(!busy, "R8", "busy during done", busy, 0);
                check(!done_prev, "R8", "done longer than one cycle", done_prev, 0);
                if (exp_q.size() == 0) begin
                    check(0, "R9", "done without accepted start", 1, 0);
                end else begin
                    last_exp = exp_q.pop_front();
                    check(int'(best_m) == last_exp.m, "R2/R5", "best_m", best_m, last_exp.m);
                    check(int'(best_n) == last_exp.n, "R2/R5", "best_n", best_n, last_exp.n);
                    check(longint'(best_rate) == last_exp.r, "R3/R4", "best_rate",
                          best_rate, last_exp.r);
                end
            end else if (!busy) begin
                check(int'(best_m) == last_exp.m && int'(best_n) == last_exp.n &&
                      longint'(best_rate) == last_exp.r, "R8", "idle hold of best_rate",
                      best_rate, last_exp.r);
            end
            if (start && !busy) begin
                exp_q.push_back(model(parent_rate, target_rate, pre_div, m_offset));
                want_busy = 1'b1;
            end
            done_prev = done;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 190000);
            summary();
            $finish;
        end
    end

    task automatic load(input longint p, input longint t, input longint pre,
                        input longint off);
        parent_rate = 32'(p);
        target_rate = 32'(t);
        pre_div     = 8'(pre);
        m_offset    = 8'(off);
    endtask

    task automatic wait_done();
        do begin
            @(posedge clk); #1;
        end while (!done);
    endtask

    task automatic run(input longint p, input longint t, input longint pre,
                       input longint off);
        load(p, t, pre, off);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        wait_done();
        @(posedge clk); #1;
    endtask

    initial begin
        last_exp.m = 0; last_exp.n = 0; last_exp.r = 0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
        check(best_m == 0 && best_n == 0 && best_rate == 0, "R1", "outputs after reset",
              best_rate, 0);
        @(posedge clk); #1;

        run(100_000_000, 100_000, 1, 1);          // R3 general case
        run(99_999_999, 77_777, 7, 3);            // R3 truncation with odd pre-divider
        run(100_000_000, 1, 1, 1);                // R4 R6 nothing fits
        run(1000, 50, 1, 1);                      // R5 tie: M0 N1 before M1 N0
        run(24_000_000, 300_000, 2, 0);           // R7 zero-offset pair skipped
        run(50_000_000, 400_000, 0, 2);           // R7 zero pre-divider
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1);  // R3 full-width rates

        // R9: start with new values mid-search is ignored
        load(48_000_000, 12_345, 3, 2);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (200) @(posedge clk);
        #1 load(1000, 50, 1, 1);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        wait_done();
        @(posedge clk); #1;

        // R10: start held through done launches the next search at once
        load(60_000_000, 250_000, 4, 1);
        start = 1'b1;
        wait_done();
        wait_done();
        start = 1'b0;
        @(posedge clk); #1;
        repeat (3) @(posedge clk);
        #1;
        check(exp_q.size() == 0, "R9", "unmatched expected results", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule